// File: doc/BRIEF.md
# Master-side coherence probe handler

This block sits in a caching master and answers snoop probes sent by the coherent interconnect. A probe names a line, asks for one of two actions and carries a tag. The action is either to drop the line or to demote it to a shared copy. The block keeps a small table of per-line state bits: valid, unique, owner and dirty. It updates the addressed entry when it accepts the probe. It then produces exactly one answer. When the line holds owned, dirty data, the answer is a write-back on the write command stream, tagged with the probe's tag. In every other case the answer is a bare completion on the probe response stream, also tagged.

Write-backs caused by probes share the normal write path of the master. There is no separate snoop data channel. The block can be told that the master still has its own writes outstanding. While that is the case it holds off new probes, so a probe answer never overtakes an earlier write. The master's own cache logic loads line state through a plain fill port. A combinational lookup port shows the current state of any line.

All three streams use valid/ready. A source holds valid and its payload unchanged until the cycle in which ready is high. The block raises the probe stream's ready only when it has no answer waiting and no outstanding-write indication. It holds each answer stable until the downstream side accepts it. The slave is expected to keep the response stream's ready high except when bandwidth is short.

Top module: `probe_handler`

## Requirements
- R1: After reset every line reads back as all-zero state, no answer is valid, and the probe stream is ready when no outstanding-write indication is present.
- R2: An accepted drop probe (op code 0) leaves the addressed line with all four state bits zero, visible on the lookup port from the cycle after acceptance.
- R3: An accepted demote probe (op code 1) clears the unique bit of a valid line and keeps valid set. On a line that is not valid it leaves the state all-zero.
- R4: A drop probe that hits a line that is valid, owner and dirty produces a write command of kind 0 (write-and-invalidate). The command carries the probe's line index and tag, and no probe response is produced.
- R5: A demote probe that hits a line that is valid, owner and dirty produces a write command of kind 1 (write-and-share) with the probe's index and tag. The line becomes valid, shared, owner and clean (state bits {v,u,o,d} = 4'b1010).
- R6: A probe to a line that is invalid or not owner produces a probe response carrying the probe's tag and no write command.
- R7: Each accepted probe yields exactly one answer, registered and valid in the cycle after acceptance. A probe response and a write command are never valid together.
- R8: While the outstanding-write input is high, the probe stream's ready is low and no probe is taken.
- R9: While an answer waits for its ready, the payload stays stable and no further probe is accepted. The answer leaves on the first edge where ready is high.
- R10: A probe to a line that is owner but clean answers with a probe response and no write-back. A demote probe keeps the owner bit of that line.
- R11: A fill writes the given state bits (bit 3 valid, bit 2 unique, bit 1 owner, bit 0 dirty) into the addressed line, visible on the lookup port the next cycle. If a fill and an accepted probe target the same line in one cycle, the probe's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_en | input | 1 | Load line state |
| fill_idx | input | IDXW | Line to load |
| fill_state | input | 4 | State bits {v,u,o,d} to load |
| look_idx | input | IDXW | Line to inspect |
| look_state | output | 4 | Current state bits of look_idx |
| own_wr_busy | input | 1 | Master has writes in flight |
| prb_valid | input | 1 | Probe command valid |
| prb_ready | output | 1 | Probe command accepted when high with valid |
| prb_op | input | 1 | 0 drop, 1 demote |
| prb_idx | input | IDXW | Probed line |
| prb_tag | input | TAGW | Probe tag |
| rsp_valid | output | 1 | Probe completion valid |
| rsp_ready | input | 1 | Completion accepted |
| rsp_tag | output | TAGW | Tag of completed probe |
| wb_valid | output | 1 | Probe write-back valid |
| wb_ready | input | 1 | Write-back accepted |
| wb_kind | output | 1 | 0 write-and-invalidate, 1 write-and-share |
| wb_idx | output | IDXW | Line written back |
| wb_tag | output | TAGW | Tag of the probe that caused it |

## Verification
The assertions assume the upstream side follows valid/ready rules. They also assume the fill port never targets a line in the same cycle a probe to that line is taken, except where R11 defines the outcome. The directed bench drives every input on the falling edge and keeps each probe valid until it sees ready. It issues fills only while no probe is being presented, and it changes the outstanding-write input only between probes. Its checks read the answer streams and the lookup port half a cycle after the accepting edge.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef struct packed {
    logic v;
    logic u;
    logic o;
    logic d;
  } line_st_t;

  typedef enum logic { OP_DROP = 1'b0, OP_DEMOTE = 1'b1 } probe_op_e;
  typedef enum logic { WB_INVAL = 1'b0, WB_SHARE = 1'b1 } wb_kind_e;
endpackage

// File: rtl/probe_state_table.sv
module probe_state_table
  import probe_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  line_st_t        fill_st,
  input  logic            upd_en,
  input  logic [IDXW-1:0] upd_idx,
  input  line_st_t        upd_st,
  input  logic [IDXW-1:0] rd_a_idx,
  output line_st_t        rd_a_st,
  input  logic [IDXW-1:0] rd_b_idx,
  output line_st_t        rd_b_st
);
  line_st_t tbl [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tbl[i] <= '0;
    end else begin
      if (fill_en) tbl[fill_idx] <= fill_st;
      // probe update placed last so it wins on a same-line collision (R11)
      if (upd_en) tbl[upd_idx] <= upd_st;
    end
  end

  assign rd_a_st = tbl[rd_a_idx];
  assign rd_b_st = tbl[rd_b_idx];

  assert_upd_lands_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_idx == rd_a_idx) |=>
      (tbl[$past(upd_idx)] == $past(upd_st)));
endmodule

// File: rtl/probe_decide.sv
module probe_decide
  import probe_pkg::*;
(
  input  probe_op_e op,
  input  line_st_t  cur,
  output line_st_t  nxt,
  output logic      need_wb,
  output wb_kind_e  kind
);
  always_comb begin
    need_wb = cur.v & cur.o & cur.d;
    nxt     = cur;
    kind    = WB_INVAL;
    if (op == OP_DROP) begin
      nxt = '0;
    end else begin
      kind = WB_SHARE;
      if (cur.v) begin
        nxt.u = 1'b0;
        if (need_wb) nxt.d = 1'b0;
      end
    end
  end
endmodule

// File: rtl/probe_answer_stage.sv
module probe_answer_stage
  import probe_pkg::*;
#(
  parameter int IDXW = 3,
  parameter int TAGW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_wb,
  input  wb_kind_e        load_kind,
  input  logic [IDXW-1:0] load_idx,
  input  logic [TAGW-1:0] load_tag,
  output logic            busy,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [TAGW-1:0] rsp_tag,
  output logic            wb_valid,
  input  logic            wb_ready,
  output wb_kind_e        wb_kind,
  output logic [IDXW-1:0] wb_idx,
  output logic [TAGW-1:0] wb_tag
);
  logic [TAGW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      wb_valid  <= 1'b0;
      wb_kind   <= WB_INVAL;
      wb_idx    <= '0;
      tag_q     <= '0;
    end else if (load) begin
      rsp_valid <= !load_wb;
      wb_valid  <= load_wb;
      wb_kind   <= load_kind;
      wb_idx    <= load_idx;
      tag_q     <= load_tag;
    end else begin
      if (rsp_ready) rsp_valid <= 1'b0;
      if (wb_ready)  wb_valid  <= 1'b0;
    end
  end

  assign rsp_tag = tag_q;
  assign wb_tag  = tag_q;
  assign busy    = rsp_valid | wb_valid;

  assert_one_answer_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, wb_valid}));
  assert_rsp_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag)));
  assert_wb_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=>
      (wb_valid && $stable(wb_tag) && $stable(wb_idx) && $stable(wb_kind)));
endmodule

// File: rtl/probe_handler.sv
module probe_handler
  import probe_pkg::*;
#(
  parameter int LINES = 8,
  parameter int TAGW  = 4,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fill_en,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [3:0]      fill_state,
  input  logic [IDXW-1:0] look_idx,
  output logic [3:0]      look_state,
  input  logic            own_wr_busy,
  input  logic            prb_valid,
  output logic            prb_ready,
  input  logic            prb_op,
  input  logic [IDXW-1:0] prb_idx,
  input  logic [TAGW-1:0] prb_tag,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [TAGW-1:0] rsp_tag,
  output logic            wb_valid,
  input  logic            wb_ready,
  output logic            wb_kind,
  output logic [IDXW-1:0] wb_idx,
  output logic [TAGW-1:0] wb_tag
);
  line_st_t  cur_st, nxt_st, look_st;
  logic      need_wb, busy, fire;
  wb_kind_e  kind, wb_kind_e_q;
  probe_op_e op;

  assign op        = probe_op_e'(prb_op);
  assign prb_ready = !busy && !own_wr_busy;
  assign fire      = prb_valid && prb_ready;

  probe_state_table #(.LINES(LINES)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_st(line_st_t'(fill_state)),
    .upd_en(fire), .upd_idx(prb_idx), .upd_st(nxt_st),
    .rd_a_idx(prb_idx), .rd_a_st(cur_st),
    .rd_b_idx(look_idx), .rd_b_st(look_st)
  );

  probe_decide u_dec (
    .op(op), .cur(cur_st), .nxt(nxt_st), .need_wb(need_wb), .kind(kind)
  );

  probe_answer_stage #(.IDXW(IDXW), .TAGW(TAGW)) u_ans (
    .clk(clk), .rst_n(rst_n),
    .load(fire), .load_wb(need_wb), .load_kind(kind),
    .load_idx(prb_idx), .load_tag(prb_tag),
    .busy(busy),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_kind(wb_kind_e_q),
    .wb_idx(wb_idx), .wb_tag(wb_tag)
  );

  assign wb_kind    = wb_kind_e_q;
  assign look_state = look_st;

  assert_answer_next_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> $onehot({rsp_valid, wb_valid}));
  assert_hold_off_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    own_wr_busy |-> !prb_ready);
  assert_wb_tag_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wb_valid -> (wb_tag == $past(prb_tag) && wb_idx == $past(prb_idx))));
  assert_rsp_tag_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rsp_valid -> rsp_tag == $past(prb_tag)));
endmodule

// File: tb/probe_handler_tb_top.sv
module probe_handler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int TAGW  = 4;
  localparam int IDXW  = $clog2(LINES);

  logic clk = 0, rst_n = 0;
  logic fill_en = 0; logic [IDXW-1:0] fill_idx = '0; logic [3:0] fill_state = '0;
  logic [IDXW-1:0] look_idx = '0; logic [3:0] look_state;
  logic own_wr_busy = 0;
  logic prb_valid = 0, prb_ready, prb_op = 0;
  logic [IDXW-1:0] prb_idx = '0; logic [TAGW-1:0] prb_tag = '0;
  logic rsp_valid, rsp_ready = 1; logic [TAGW-1:0] rsp_tag;
  logic wb_valid, wb_ready = 1, wb_kind; logic [IDXW-1:0] wb_idx; logic [TAGW-1:0] wb_tag;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  probe_handler #(.LINES(LINES), .TAGW(TAGW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input int idx, input logic [3:0] st);
    @(negedge clk);
    fill_en = 1; fill_idx = IDXW'(idx); fill_state = st;
    @(negedge clk);
    fill_en = 0;
  endtask

  // present a probe; returns at the negedge after acceptance
  task automatic probe(input logic op, input int idx, input int tag);
    @(negedge clk);
    prb_valid = 1; prb_op = op; prb_idx = IDXW'(idx); prb_tag = TAGW'(tag);
    while (!prb_ready) @(negedge clk);
    @(negedge clk);
    prb_valid = 0;
    look_idx = IDXW'(idx);
    #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < LINES; i++) begin
      look_idx = IDXW'(i); #1;
      chk("R1 state", look_state, 4'b0000);
    end
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 prb_ready", prb_ready, 1);
  endtask

  task automatic t_fill();
    fill(7, 4'b1101);
    look_idx = 7; #1;
    chk("R11 fill visible", look_state, 4'b1101);
  endtask

  task automatic t_drop_clean();
    fill(2, 4'b1100);
    probe(0, 2, 3);
    chk("R6 rsp_valid", rsp_valid, 1);
    chk("R6 rsp_tag", rsp_tag, 3);
    chk("R6 no wb", wb_valid, 0);
    chk("R2 line dropped", look_state, 4'b0000);
    @(negedge clk);
    chk("R7 rsp gone", rsp_valid, 0);
  endtask

  task automatic t_demote_nonowner();
    fill(1, 4'b1100);
    probe(1, 1, 5);
    chk("R6 rsp_valid", rsp_valid, 1);
    chk("R6 rsp_tag", rsp_tag, 5);
    chk("R3 shared", look_state, 4'b1000);
  endtask

  task automatic t_demote_invalid();
    probe(1, 4, 6);
    chk("R6 rsp on invalid", rsp_valid, 1);
    chk("R3 stays invalid", look_state, 4'b0000);
  endtask

  task automatic t_drop_dirty();
    fill(3, 4'b1111);
    probe(0, 3, 9);
    chk("R4 wb_valid", wb_valid, 1);
    chk("R4 wb_kind", wb_kind, 0);
    chk("R4 wb_idx", wb_idx, 3);
    chk("R4 wb_tag", wb_tag, 9);
    chk("R4 no rsp", rsp_valid, 0);
    chk("R2 dirty dropped", look_state, 4'b0000);
  endtask

  task automatic t_demote_dirty();
    fill(5, 4'b1111);
    probe(1, 5, 12);
    chk("R5 wb_valid", wb_valid, 1);
    chk("R5 wb_kind", wb_kind, 1);
    chk("R5 wb_tag", wb_tag, 12);
    chk("R7 no rsp", rsp_valid, 0);
    chk("R5 state", look_state, 4'b1010);
  endtask

  task automatic t_owner_clean();
    fill(6, 4'b1110);
    probe(1, 6, 7);
    chk("R10 rsp", rsp_valid, 1);
    chk("R10 no wb", wb_valid, 0);
    chk("R10 state", look_state, 4'b1010);
  endtask

  task automatic t_wr_busy();
    fill(0, 4'b1100);
    @(negedge clk);
    own_wr_busy = 1;
    prb_valid = 1; prb_op = 0; prb_idx = 0; prb_tag = 4'd2;
    look_idx = 0;
    repeat (3) @(negedge clk);
    chk("R8 ready low", prb_ready, 0);
    chk("R8 no answer", rsp_valid, 0);
    chk("R8 state kept", look_state, 4'b1100);
    own_wr_busy = 0;
    @(negedge clk);
    prb_valid = 0; #1;
    chk("R8 answered after", rsp_valid, 1);
    chk("R8 tag", rsp_tag, 2);
  endtask

  task automatic t_backpressure();
    fill(2, 4'b1100);
    rsp_ready = 0;
    probe(1, 2, 11);
    chk("R9 rsp_valid", rsp_valid, 1);
    @(negedge clk);
    chk("R9 held", rsp_valid, 1);
    chk("R9 tag stable", rsp_tag, 11);
    chk("R9 ready low", prb_ready, 0);
    rsp_ready = 1;
    @(negedge clk);
    chk("R9 released", rsp_valid, 0);
    chk("R9 ready back", prb_ready, 1);
  endtask

  task automatic t_collision();
    fill(4, 4'b1111);
    @(negedge clk);
    prb_valid = 1; prb_op = 0; prb_idx = 4; prb_tag = 1;
    fill_en = 1; fill_idx = 4; fill_state = 4'b1100;
    @(negedge clk);
    prb_valid = 0; fill_en = 0; look_idx = 4; #1;
    chk("R11 probe wins", look_state, 4'b0000);
    chk("R4 wb on collision", wb_valid, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_drop_clean();
    t_demote_nonowner();
    t_demote_invalid();
    t_drop_dirty();
    t_demote_dirty();
    t_owner_clean();
    t_wr_busy();
    t_backpressure();
    t_collision();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule